// File: doc/BRIEF.md
# Keyed Configuration Port with Logical-Device Banking

This block sits on a byte-wide I/O bus and exposes two addresses: an index port and a data port. A bank of configuration registers can only be reached through them after host software unlocks the block. It unlocks by writing a four-byte key to the index port. Once unlocked, software writes a register number to the index port and then reads or writes that register through the data port. Writing a particular value to a particular index locks the block again.

Register numbers below the device window are global: the logical-device selector, the chip identifier and the revision. Register numbers from the device window upward are banked. The same index reaches a separate activate flag and a separate 16-bit base address for each implemented logical device, chosen by the selector.

Every data-port write accepted while unlocked is also published on a one-cycle strobe. The strobe carries the selector value, the index and the byte, so that downstream blocks can implement further registers of their own. The current selector is also driven out continuously.

Top module: `cfgport_gate`

## Requirements
- R1: After reset the block is locked, `unlocked` is 0, `ldn` is 0, and the index register is 0.
- R2: Writing 0x87, 0x01, 0x55, 0x55 to the index port as consecutive index-port writes sets `unlocked` to 1 on the clock edge that captures the last byte.
- R3: While locked, an index-port byte that does not match the next expected key byte restarts matching. If that byte is 0x87 it is taken as the first key byte of a new attempt.
- R4: While locked, data-port writes change no register and raise no strobe, and reads of either port return 0xFF.
- R5: While unlocked, an index-port write stores the byte as the current index, and an index-port read returns it.
- R6: Index 0x07 is the logical-device selector. A data write there updates `ldn`, and a data read returns it.
- R7: Index 0x20 reads the high byte of CHIP_ID and index 0x21 reads the low byte. Index 0x22 reads CHIP_REV in bits 3:0 with bits 7:4 zero. Writes to these three indices do not change them.
- R8: For each implemented device (selector below NUM_DEV), index 0x30 bit 0 is an activate flag and indices 0x60 and 0x61 hold the high and low bytes of a base address. Each device keeps its own copy.
- R9: With the selector at NUM_DEV or above, reads of index 0x30 and higher return 0xFF, and data writes there leave every device's registers unchanged.
- R10: Each data-port write accepted while unlocked raises `cfg_wr_stb` for exactly the next cycle. The strobe carries the selector value before the write, the index and the byte.
- R11: While unlocked, a data write of 0x02 with the index at 0x02 locks the block and clears the index to 0. Any other byte written at index 0x02 leaves the block unlocked. A new key sequence is then needed.
- R12: `bus_rdata` updates one cycle after a read of the index or data port. Reads and writes at any other address leave all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | I/O address of the current access |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after a port read |
| unlocked | output | 1 | High while configuration access is open |
| ldn | output | 8 | Current logical-device selector |
| cfg_wr_stb | output | 1 | One-cycle pulse per accepted data write |
| cfg_wr_ldn | output | 8 | Selector value in force at that write |
| cfg_wr_idx | output | 8 | Index of that write |
| cfg_wr_data | output | 8 | Byte of that write |

## Verification
The bench builds the block with NUM_DEV set to 3, so that selector value 3 falls just past the implemented devices and the out-of-range banking path is reachable. CHIP_ID is set to 0xA5C3 and CHIP_REV to 6. With these values, swapped identifier bytes or an unmasked revision nibble produce visibly wrong read data. Keeping the default port addresses means the key, the exit and the stray-address cases run at the same addresses software would use.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int BYTE_W  = 8;
    localparam int KEY_LEN = 4;

    // key bytes in write order, element 0 first
    localparam logic [KEY_LEN-1:0][BYTE_W-1:0] KEY_SEQ =
        {8'h55, 8'h55, 8'h01, 8'h87};

    localparam logic [BYTE_W-1:0] IDX_LDN     = 8'h07;
    localparam logic [BYTE_W-1:0] IDX_EXIT    = 8'h02;
    localparam logic [BYTE_W-1:0] EXIT_VALUE  = 8'h02;
    localparam logic [BYTE_W-1:0] IDX_ID_HI   = 8'h20;
    localparam logic [BYTE_W-1:0] IDX_ID_LO   = 8'h21;
    localparam logic [BYTE_W-1:0] IDX_REV     = 8'h22;
    localparam logic [BYTE_W-1:0] IDX_DEV_LO  = 8'h30;
    localparam logic [BYTE_W-1:0] IDX_ACT     = 8'h30;
    localparam logic [BYTE_W-1:0] IDX_BASE_HI = 8'h60;
    localparam logic [BYTE_W-1:0] IDX_BASE_LO = 8'h61;

    localparam logic [BYTE_W-1:0] LOCKED_RD   = 8'hFF;

    typedef struct packed {
        logic              unlocked;
        logic [BYTE_W-1:0] idx;
        logic [BYTE_W-1:0] ldn;
        logic [BYTE_W-1:0] rdata;
        logic              wr_stb;
        logic [BYTE_W-1:0] wr_ldn;
        logic [BYTE_W-1:0] wr_idx;
        logic [BYTE_W-1:0] wr_data;
    } port_state_t;

    typedef struct packed {
        logic        act;
        logic [15:0] base;
    } dev_regs_t;

endpackage

// File: rtl/cfgport_keyseq.sv
module cfgport_keyseq
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [BYTE_W-1:0] key_byte,
    output logic              key_hit
);
    localparam int CNT_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_LEN - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        key_hit = 1'b0;
        if (key_wr) begin
            if (key_byte == KEY_SEQ[cnt_q]) begin
                if (cnt_q == LAST) begin
                    key_hit = 1'b1;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end else if (key_byte == KEY_SEQ[0]) begin
                cnt_d = CNT_W'(1);
            end else begin
                cnt_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/cfgport_devbank.sv
module cfgport_devbank
    import cfgport_pkg::*;
#(
    parameter int NUM_DEV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] sel_ldn,
    input  logic [BYTE_W-1:0] wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              sel_valid,
    output logic              sel_act,
    output logic [15:0]       sel_base
);
    dev_regs_t dev_q_arr [NUM_DEV];

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        dev_regs_t r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (wr_en && (int'(sel_ldn) == g)) begin
                case (wr_idx)
                    IDX_ACT:     r_d.act        = wr_data[0];
                    IDX_BASE_HI: r_d.base[15:8] = wr_data;
                    IDX_BASE_LO: r_d.base[7:0]  = wr_data;
                    default:     r_d            = r_q;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= r_d;
        end

        assign dev_q_arr[g] = r_q;
    end

    always_comb begin
        sel_valid = 1'b0;
        sel_act   = 1'b0;
        sel_base  = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (int'(sel_ldn) == i) begin
                sel_valid = 1'b1;
                sel_act   = dev_q_arr[i].act;
                sel_base  = dev_q_arr[i].base;
            end
        end
    end

endmodule

// File: rtl/cfgport_rdmux.sv
module cfgport_rdmux
    import cfgport_pkg::*;
#(
    parameter logic [15:0] CHIP_ID  = 16'h5A01,
    parameter logic [3:0]  CHIP_REV = 4'h3
) (
    input  logic              unlocked,
    input  logic              at_idx_port,
    input  logic [BYTE_W-1:0] idx,
    input  logic [BYTE_W-1:0] ldn,
    input  logic              dev_valid,
    input  logic              dev_act,
    input  logic [15:0]       dev_base,
    output logic [BYTE_W-1:0] rbyte
);
    always_comb begin
        rbyte = LOCKED_RD;
        if (unlocked) begin
            if (at_idx_port) begin
                rbyte = idx;
            end else if (idx >= IDX_DEV_LO) begin
                if (!dev_valid) begin
                    rbyte = LOCKED_RD;
                end else begin
                    case (idx)
                        IDX_ACT:     rbyte = {7'd0, dev_act};
                        IDX_BASE_HI: rbyte = dev_base[15:8];
                        IDX_BASE_LO: rbyte = dev_base[7:0];
                        default:     rbyte = 8'h00;
                    endcase
                end
            end else begin
                case (idx)
                    IDX_LDN:   rbyte = ldn;
                    IDX_ID_HI: rbyte = CHIP_ID[15:8];
                    IDX_ID_LO: rbyte = CHIP_ID[7:0];
                    IDX_REV:   rbyte = {4'h0, CHIP_REV};
                    default:   rbyte = 8'h00;
                endcase
            end
        end
    end

endmodule

// File: rtl/cfgport_gate.sv
module cfgport_gate
    import cfgport_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h002E,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h002F,
    parameter int              NUM_DEV   = 8,
    parameter logic [15:0]     CHIP_ID   = 16'h5A01,
    parameter logic [3:0]      CHIP_REV  = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              unlocked,
    output logic [7:0]        ldn,
    output logic              cfg_wr_stb,
    output logic [7:0]        cfg_wr_ldn,
    output logic [7:0]        cfg_wr_idx,
    output logic [7:0]        cfg_wr_data
);
    port_state_t d, q;

    logic              at_idx, at_dat;
    logic              key_wr, key_hit;
    logic              idx_wr_ok, dat_wr_ok, port_rd;
    logic              dev_valid, dev_act;
    logic [15:0]       dev_base;
    logic [BYTE_W-1:0] rd_byte;

    assign at_idx    = (bus_addr == IDX_PORT);
    assign at_dat    = (bus_addr == DATA_PORT);
    assign key_wr    = bus_wr && at_idx && !q.unlocked;
    assign idx_wr_ok = bus_wr && at_idx && q.unlocked;
    assign dat_wr_ok = bus_wr && at_dat && q.unlocked;
    assign port_rd   = bus_rd && (at_idx || at_dat);

    cfgport_keyseq u_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (bus_wdata),
        .key_hit  (key_hit)
    );

    cfgport_devbank #(.NUM_DEV(NUM_DEV)) u_devbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (dat_wr_ok),
        .sel_ldn   (q.ldn),
        .wr_idx    (q.idx),
        .wr_data   (bus_wdata),
        .sel_valid (dev_valid),
        .sel_act   (dev_act),
        .sel_base  (dev_base)
    );

    cfgport_rdmux #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_rdmux (
        .unlocked    (q.unlocked),
        .at_idx_port (at_idx),
        .idx         (q.idx),
        .ldn         (q.ldn),
        .dev_valid   (dev_valid),
        .dev_act     (dev_act),
        .dev_base    (dev_base),
        .rbyte       (rd_byte)
    );

    always_comb begin
        d        = q;
        d.wr_stb = 1'b0;

        if (key_hit) d.unlocked = 1'b1;

        if (idx_wr_ok) d.idx = bus_wdata;

        if (dat_wr_ok) begin
            d.wr_stb  = 1'b1;
            d.wr_ldn  = q.ldn;
            d.wr_idx  = q.idx;
            d.wr_data = bus_wdata;
            if (q.idx == IDX_LDN) d.ldn = bus_wdata;
            if ((q.idx == IDX_EXIT) && (bus_wdata == EXIT_VALUE)) begin
                d.unlocked = 1'b0;
                d.idx      = '0;
            end
        end

        if (port_rd) d.rdata = rd_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.rdata <= LOCKED_RD;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata   = q.rdata;
    assign unlocked    = q.unlocked;
    assign ldn         = q.ldn;
    assign cfg_wr_stb  = q.wr_stb;
    assign cfg_wr_ldn  = q.wr_ldn;
    assign cfg_wr_idx  = q.wr_idx;
    assign cfg_wr_data = q.wr_data;

endmodule

// File: rtl/cfgport_gate_chk.sv
module cfgport_gate_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h002E,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h002F
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              unlocked,
    input logic [7:0]        ldn,
    input logic              cfg_wr_stb,
    input logic [7:0]        cfg_wr_data
);
    logic our_rd;
    assign our_rd = bus_rd && ((bus_addr == IDX_PORT) || (bus_addr == DATA_PORT));

    AST_LOCKED_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && bus_wr && bus_addr == DATA_PORT) |=> !cfg_wr_stb); // R4
    AST_LOCKED_RD_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && our_rd) |=> (bus_rdata == 8'hFF)); // R4
    AST_UNLOCK_LAST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_wr && bus_addr == IDX_PORT && bus_wdata == 8'h55)); // R2
    AST_LOCK_EXIT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlocked) |-> $past(bus_wr && bus_addr == DATA_PORT && bus_wdata == 8'h02)); // R11
    AST_LDN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ldn) |-> $past(unlocked && bus_wr && bus_addr == DATA_PORT)); // R6
    AST_STB_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_stb |-> $past(unlocked && bus_wr && bus_addr == DATA_PORT)); // R10
    AST_STB_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_stb |-> (cfg_wr_data == $past(bus_wdata))); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(our_rd) |-> $stable(bus_rdata)); // R12

endmodule

bind cfgport_gate cfgport_gate_chk #(
    .ADDR_W    (ADDR_W),
    .IDX_PORT  (IDX_PORT),
    .DATA_PORT (DATA_PORT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .unlocked    (unlocked),
    .ldn         (ldn),
    .cfg_wr_stb  (cfg_wr_stb),
    .cfg_wr_data (cfg_wr_data)
);

// File: tb/cfgport_gate_tb.sv
`timescale 1ns/1ps
module cfgport_gate_tb;
    localparam logic [15:0] IDXP = 16'h002E;
    localparam logic [15:0] DATP = 16'h002F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata, ldn, cfg_wr_ldn, cfg_wr_idx, cfg_wr_data;
    logic        unlocked, cfg_wr_stb;

    always #2 clk = ~clk;

    cfgport_gate #(
        .NUM_DEV(3), .CHIP_ID(16'hA5C3), .CHIP_REV(4'h6)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .unlocked(unlocked), .ldn(ldn), .cfg_wr_stb(cfg_wr_stb),
        .cfg_wr_ldn(cfg_wr_ldn), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data)
    );

    int n_tests = 0, n_fail = 0;
    logic [7:0]  rd_exp_q[$];
    string       rd_req_q[$];
    logic [23:0] wr_exp_q[$];
    logic [7:0]  tb_ldn = 8'h00;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic port_read(input logic [15:0] a, input logic [7:0] exp, input string req);
        rd_exp_q.push_back(exp);
        rd_req_q.push_back(req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // unlocked register write: index then data, strobe expected
    task automatic reg_wr(input logic [7:0] i, input logic [7:0] v);
        bus_write(IDXP, i);
        wr_exp_q.push_back({tb_ldn, i, v});
        bus_write(DATP, v);
        if (i == 8'h07) tb_ldn = v;
    endtask

    task automatic reg_rd(input logic [7:0] i, input logic [7:0] exp, input string req);
        bus_write(IDXP, i);
        port_read(DATP, exp, req);
    endtask

    task automatic send_key();
        bus_write(IDXP, 8'h87); bus_write(IDXP, 8'h01);
        bus_write(IDXP, 8'h55); bus_write(IDXP, 8'h55);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // monitor: pops expected reads and strobes as the design produces them
    initial begin
        logic cap_rd;
        forever begin
            @(posedge clk);
            cap_rd = bus_rd && (bus_addr == IDXP || bus_addr == DATP) && rst_n;
            @(negedge clk);
            if (cap_rd) begin
                if (rd_exp_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R12 actual=unexpected read expected=none");
                end else begin
                    logic [7:0] e;
                    string r;
                    e = rd_exp_q.pop_front();
                    r = rd_req_q.pop_front();
                    check(r, {24'd0, bus_rdata}, {24'd0, e});
                end
            end
            if (cfg_wr_stb) begin
                if (wr_exp_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R10 actual=strobe %0h expected=none", cfg_wr_data);
                end else begin
                    check("R10 strobe fields", {8'd0, cfg_wr_ldn, cfg_wr_idx, cfg_wr_data},
                          {8'd0, wr_exp_q.pop_front()});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 unlocked", {31'd0, unlocked}, 0);
        check("R1 ldn", {24'd0, ldn}, 0);
        // R4 locked reads and ignored writes
        port_read(IDXP, 8'hFF, "R4 locked index read");
        port_read(DATP, 8'hFF, "R4 locked data read");
        bus_write(DATP, 8'h07);
        bus_write(DATP, 8'h02);
        check("R4 still locked", {31'd0, unlocked}, 0);
        check("R4 ldn untouched", {24'd0, ldn}, 0);
        // R2 clean key
        bus_write(IDXP, 8'h87); bus_write(IDXP, 8'h01); bus_write(IDXP, 8'h55);
        check("R2 locked before last key", {31'd0, unlocked}, 0);
        bus_write(IDXP, 8'h55);
        check("R2 unlocked after key", {31'd0, unlocked}, 1);
        // R1 index reset value, R5 index port
        port_read(IDXP, 8'h00, "R1 index after reset");
        bus_write(IDXP, 8'h4C);
        port_read(IDXP, 8'h4C, "R5 index readback");
        // R7 identification
        reg_rd(8'h20, 8'hA5, "R7 id high");
        reg_rd(8'h21, 8'hC3, "R7 id low");
        reg_rd(8'h22, 8'h06, "R7 revision");
        reg_wr(8'h20, 8'h00);
        reg_wr(8'h22, 8'hFF);
        reg_rd(8'h20, 8'hA5, "R7 id read-only");
        reg_rd(8'h22, 8'h06, "R7 rev read-only");
        // R6 selector
        reg_wr(8'h07, 8'h01);
        check("R6 ldn output", {24'd0, ldn}, 1);
        reg_rd(8'h07, 8'h01, "R6 ldn readback");
        // R8 banked registers
        reg_wr(8'h30, 8'h01); reg_wr(8'h60, 8'h12); reg_wr(8'h61, 8'h34);
        reg_wr(8'h07, 8'h02);
        reg_wr(8'h60, 8'hBE);
        reg_rd(8'h30, 8'h00, "R8 dev2 act separate");
        reg_rd(8'h60, 8'hBE, "R8 dev2 base hi");
        reg_rd(8'h61, 8'h00, "R8 dev2 base lo");
        reg_wr(8'h07, 8'h01);
        reg_rd(8'h30, 8'h01, "R8 dev1 act");
        reg_rd(8'h60, 8'h12, "R8 dev1 base hi");
        reg_rd(8'h61, 8'h34, "R8 dev1 base lo");
        // R9 out-of-range selector
        reg_wr(8'h07, 8'h03);
        reg_wr(8'h60, 8'h99); reg_wr(8'h30, 8'h01);
        reg_rd(8'h60, 8'hFF, "R9 unimplemented dev read");
        reg_rd(8'h30, 8'hFF, "R9 unimplemented act read");
        reg_rd(8'h07, 8'h03, "R9 selector still readable");
        reg_wr(8'h07, 8'h00);
        reg_rd(8'h60, 8'h00, "R9 dev0 untouched");
        reg_rd(8'h30, 8'h00, "R9 dev0 act untouched");
        reg_wr(8'h07, 8'h02);
        reg_rd(8'h60, 8'hBE, "R9 dev2 untouched");
        // R12 other addresses ignored
        bus_write(16'h0080, 8'h55);
        @(negedge clk); bus_addr = 16'h0081; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        check("R12 rdata held on stray read", {24'd0, bus_rdata}, 32'hBE);
        check("R12 stray write no lock change", {31'd0, unlocked}, 1);
        // R11 exit
        reg_wr(8'h02, 8'h05);
        check("R11 other byte keeps unlocked", {31'd0, unlocked}, 1);
        reg_wr(8'h02, 8'h02);
        check("R11 locked after exit", {31'd0, unlocked}, 0);
        port_read(IDXP, 8'hFF, "R11 locked index read");
        check("R11 ldn kept", {24'd0, ldn}, 2);
        // R3 wrong byte restarts
        bus_write(IDXP, 8'h87); bus_write(IDXP, 8'h01); bus_write(IDXP, 8'h55);
        bus_write(IDXP, 8'h01);
        bus_write(IDXP, 8'h55);
        check("R3 broken key stays locked", {31'd0, unlocked}, 0);
        // R3 0x87 in mid-sequence restarts as first byte
        bus_write(IDXP, 8'h87); bus_write(IDXP, 8'h01); bus_write(IDXP, 8'h55);
        bus_write(IDXP, 8'h87); bus_write(IDXP, 8'h01); bus_write(IDXP, 8'h55);
        bus_write(IDXP, 8'h55);
        check("R3 restart on 0x87 unlocks", {31'd0, unlocked}, 1);
        port_read(IDXP, 8'h00, "R11 index cleared by exit");
        reg_wr(8'h02, 8'h02);
        bus_write(IDXP, 8'h87); bus_write(IDXP, 8'h87); bus_write(IDXP, 8'h01);
        bus_write(IDXP, 8'h55); bus_write(IDXP, 8'h55);
        check("R3 repeated 0x87 unlocks", {31'd0, unlocked}, 1);
        send_key();
        check("R5 key bytes while unlocked are plain index writes", {31'd0, unlocked}, 1);
        port_read(IDXP, 8'h55, "R5 last index byte");
        repeat (4) @(negedge clk);
        check("R10 all strobes seen", wr_exp_q.size(), 0);
        check("R12 all reads seen", rd_exp_q.size(), 0);
        finish_run();
    end

endmodule